// File: doc/BRIEF.md
# Layered Min-Sum LDPC Check-Node Decoder Core

This block runs layered belief-propagation decoding of a quasi-cyclic LDPC code with normalised min-sum. Host logic first loads a small posterior memory of `NV` variable-node groups, each holding `Z` signed 8-bit soft values (lanes). It then presents a row table that gives, for every check row (layer) and every group, either a circular shift or an "absent" marker, and pulses `start`. The core walks the layers in order. For each layer it makes two passes over the group slots. The first pass forms variable-to-check messages and tracks, per lane, the two smallest magnitudes, the position of the smallest and the sign product. The second pass computes the scaled check-to-variable messages, updates the posteriors incrementally and stores the new messages.

After the last layer of each iteration, the core evaluates the parity checks on the hard decisions. It stops early when they are all satisfied and early stop is enabled, or when the iteration limit is reached. It then reports the iteration count and the parity outcome and pulses `done`. The host reads the decoded posteriors back one group at a time.

Top module: `ldpc_layer_dec`

## Requirements
- R1: A load (`ld_en`) while idle writes group `ld_grp`, with each lane clamped to [-64, +64]. `rd_data` shows group `rd_grp` one clock after the address is presented.
- R2: For each connected edge and lane, the variable-to-check value is the posterior minus the stored check message for that edge, clamped to [-64, +64]. A value of zero counts as positive.
- R3: Per lane, the core finds the smallest and second-smallest variable-to-check magnitudes (both start at 64), the first edge that holds the strict minimum, and the XOR of all signs. The edge that holds the minimum receives the second minimum. Every other edge receives the minimum. The sign of each message is the sign product with the edge's own sign removed.
- R4: A message magnitude m is scaled to floor(13·m/16).
- R5: The new posterior is the old posterior plus the new message minus the old message, clamped to [-64, +64]. No stored posterior ever leaves that range.
- R6: Table entry (row r, group g) sits at bits [(r·NV+g)·16 +: 16]. The value 0xFFFF marks no edge, and that group is neither read nor written for that row. Otherwise, with s = shift mod Z, lane l of the edge uses element (l+s) mod Z of the group, and the update goes back to that same element.
- R7: Layers run in order 0..NR-1, and each iteration ends with a parity check in which a soft value below zero is a 1 and a row with no edges is satisfied. Decoding ends after an iteration when parity holds and `early_stop` was set, or when the iteration count equals `max_iter`. A `max_iter` of 0 acts as 1.
- R8: All stored check messages are zero when a decode starts, so decoding the same posteriors twice gives the same result.
- R9: `busy` is high from the clock after an accepted `start` until `done`. `done` is a one-cycle pulse that carries `iter_count` and `parity_ok`. `start` and loads are ignored while busy.
- R10: After reset, `busy`, `done`, `parity_ok` and `iter_count` are zero, and every posterior reads back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one posterior group |
| ld_grp | input | $clog2(NV+1) | Group index for the load |
| ld_data | input | Z*8 | Lane values for the load, lane 0 in the low byte |
| rd_grp | input | $clog2(NV+1) | Group index for readback |
| rd_data | output | Z*8 | Registered readback of the group |
| shift_tab | input | NR*NV*16 | Shift per row and group, 0xFFFF for no edge |
| start | input | 1 | Begin a decode |
| max_iter | input | ITER_W | Iteration limit |
| early_stop | input | 1 | Stop once parity holds |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle completion pulse |
| iter_count | output | ITER_W | Iterations run in the last decode |
| parity_ok | output | 1 | All parity checks held at the end |

## Verification
The bench aims at min-sum corner cases. With tied minimum magnitudes, a tracker that used a non-strict comparison would hand the second edge the wrong message. When two edges are both at the clamp limit, a missing clamp would let a posterior grow past 64. With non-zero shifts, a rotation applied on read but not undone on write would scramble the lanes. Further cases cover a `max_iter` of zero, valid codewords with early stop both on and off, a second decode of identical data that would go wrong if old check messages survived, and `start` and loads injected during a run that a faulty core would act on. Random tables with absent edges are compared against a bench model. A core that touched absent groups, or flipped the sign of a zero message, would diverge from that model.

// File: rtl/ldpc_lmsa_pkg.sv
package ldpc_lmsa_pkg;
  localparam int unsigned LLR_W   = 8;
  localparam int unsigned SUM_W   = 9;
  localparam int unsigned MAG_W   = 7;
  localparam int unsigned SHIFT_W = 16;
  localparam int          LLR_LIM = 64;
  localparam logic [SHIFT_W-1:0] NO_EDGE = 16'hFFFF;

  typedef logic signed [LLR_W-1:0] llr_t;
  typedef logic signed [SUM_W-1:0] sum_t;
  typedef logic        [MAG_W-1:0] mag_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_APPLY  = 2'd2,
    ST_CHECK  = 2'd3
  } phase_t;

  // Clamp a wide sum into the soft-value range.
  function automatic llr_t clamp_llr(input sum_t x);
    if (x > sum_t'(LLR_LIM))       return llr_t'(LLR_LIM);
    else if (x < sum_t'(-LLR_LIM)) return llr_t'(-LLR_LIM);
    else                           return llr_t'(x);
  endfunction

  function automatic mag_t abs_llr(input llr_t v);
    sum_t w;
    w = sum_t'(v);
    if (w < 0) w = -w;
    return mag_t'(w);
  endfunction

  // 0.8 normalisation approximated by 13/16, truncating.
  function automatic mag_t scale_mag(input mag_t m);
    logic [MAG_W+3:0] p;
    p = (MAG_W+4)'(m) * (MAG_W+4)'(13);
    return mag_t'(p >> 4);
  endfunction
endpackage

// File: rtl/ldpc_lane_rot.sv
module ldpc_lane_rot #(
  parameter int unsigned Z   = 4,
  parameter int unsigned LW  = 8,
  parameter bit          INV = 1'b0
) (
  input  logic [Z*LW-1:0] din,
  input  logic [15:0]     shift,
  output logic [Z*LW-1:0] dout
);
  always_comb begin
    dout = '0;
    for (int l = 0; l < int'(Z); l++) begin
      if (INV) dout[((l + shift % Z) % Z)*LW +: LW] = din[l*LW +: LW];
      else     dout[l*LW +: LW] = din[((l + shift % Z) % Z)*LW +: LW];
    end
  end
endmodule

// File: rtl/ldpc_min2_track.sv
module ldpc_min2_track
  import ldpc_lmsa_pkg::*;
#(
  parameter int unsigned EW   = 3,
  parameter int unsigned NONE = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          first,
  input  logic          en,
  input  logic [EW-1:0] eidx,
  input  llr_t          v2c,
  output mag_t          min1,
  output mag_t          min2,
  output logic [EW-1:0] idx,
  output logic          sgn
);
  mag_t          mag, b1, b2;
  logic [EW-1:0] bi;
  logic          bs;

  assign mag = abs_llr(v2c);

  always_comb begin
    if (first) begin
      b1 = mag_t'(LLR_LIM);
      b2 = mag_t'(LLR_LIM);
      bi = EW'(NONE);
      bs = 1'b0;
    end else begin
      b1 = min1;
      b2 = min2;
      bi = idx;
      bs = sgn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      min1 <= mag_t'(LLR_LIM);
      min2 <= mag_t'(LLR_LIM);
      idx  <= EW'(NONE);
      sgn  <= 1'b0;
    end else if (first || en) begin
      if (en) begin
        if (mag < b1) begin
          min1 <= mag;
          min2 <= b1;
          idx  <= eidx;
        end else if (mag < b2) begin
          min1 <= b1;
          min2 <= mag;
          idx  <= bi;
        end else begin
          min1 <= b1;
          min2 <= b2;
          idx  <= bi;
        end
        sgn <= bs ^ v2c[LLR_W-1];
      end else begin
        min1 <= b1;
        min2 <= b2;
        idx  <= bi;
        sgn  <= bs;
      end
    end
  end
endmodule

// File: rtl/ldpc_parity_chk.sv
module ldpc_parity_chk
  import ldpc_lmsa_pkg::*;
#(
  parameter int unsigned Z  = 4,
  parameter int unsigned NV = 6,
  parameter int unsigned NR = 3,
  parameter int unsigned LW = 8
) (
  input  logic [NV*Z*LW-1:0]   post_flat,
  input  logic [NR*NV*16-1:0]  shift_tab,
  output logic                 ok
);
  logic        par;
  logic [15:0] s;

  always_comb begin
    ok  = 1'b1;
    par = 1'b0;
    s   = '0;
    for (int r = 0; r < int'(NR); r++) begin
      for (int l = 0; l < int'(Z); l++) begin
        par = 1'b0;
        for (int e = 0; e < int'(NV); e++) begin
          s = shift_tab[(r*int'(NV) + e)*16 +: 16];
          if (s != NO_EDGE)
            par = par ^ post_flat[(e*int'(Z) + int'((l + s % Z) % Z))*LW + LW - 1];
        end
        if (par) ok = 1'b0;
      end
    end
  end
endmodule

// File: rtl/ldpc_layer_dec.sv
module ldpc_layer_dec
  import ldpc_lmsa_pkg::*;
#(
  parameter int unsigned Z      = 4,
  parameter int unsigned NV     = 6,
  parameter int unsigned NR     = 3,
  parameter int unsigned ITER_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld_en,
  input  logic [$clog2(NV+1)-1:0]   ld_grp,
  input  logic [Z*8-1:0]            ld_data,
  input  logic [$clog2(NV+1)-1:0]   rd_grp,
  output logic [Z*8-1:0]            rd_data,
  input  logic [NR*NV*16-1:0]       shift_tab,
  input  logic                      start,
  input  logic [ITER_W-1:0]         max_iter,
  input  logic                      early_stop,
  output logic                      busy,
  output logic                      done,
  output logic [ITER_W-1:0]         iter_count,
  output logic                      parity_ok
);
  localparam int unsigned LW    = LLR_W;
  localparam int unsigned GW    = Z * LW;
  localparam int unsigned EW    = $clog2(NV + 1);
  localparam int unsigned RW    = $clog2(NR + 1);
  localparam int unsigned NSLOT = NR * NV;
  localparam int unsigned SLW   = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  phase_t              st_q;
  logic [EW-1:0]       edge_q;
  logic [RW-1:0]       row_q;
  logic [ITER_W-1:0]   iter_q, max_q;
  logic                early_q;

  logic [GW-1:0]       post_mem [NV];
  logic [GW-1:0]       c2v_mem  [NSLOT];

  logic [SLW-1:0]      slot_idx;
  logic [15:0]         cur_shift;
  logic                has_edge;
  logic                last_edge;
  logic                synd_ok;
  logic [GW-1:0]       post_grp, post_rot, old_grp;
  logic [GW-1:0]       new_c2v_grp, new_rot_grp, post_wb, ld_sat;
  logic [NV*GW-1:0]    post_flat;

  assign slot_idx  = SLW'(int'(row_q) * int'(NV) + int'(edge_q));
  assign cur_shift = shift_tab[int'(slot_idx)*16 +: 16];
  assign has_edge  = (cur_shift != NO_EDGE);
  assign last_edge = (edge_q == EW'(NV - 1));
  assign post_grp  = post_mem[edge_q];
  assign old_grp   = c2v_mem[slot_idx];

  ldpc_lane_rot #(.Z(Z), .LW(LW), .INV(1'b0)) u_rot_rd (
    .din(post_grp), .shift(cur_shift), .dout(post_rot));

  ldpc_lane_rot #(.Z(Z), .LW(LW), .INV(1'b1)) u_rot_wr (
    .din(new_rot_grp), .shift(cur_shift), .dout(post_wb));

  for (genvar g = 0; g < NV; g++) begin : g_flat
    assign post_flat[g*GW +: GW] = post_mem[g];
  end

  ldpc_parity_chk #(.Z(Z), .NV(NV), .NR(NR), .LW(LW)) u_par (
    .post_flat(post_flat), .shift_tab(shift_tab), .ok(synd_ok));

  for (genvar l = 0; l < Z; l++) begin : g_lane
    llr_t          p_l, o_l, v_l, n_l;
    mag_t          m1, m2, nm;
    logic [EW-1:0] ix;
    logic          sp;

    assign p_l = llr_t'(post_rot[l*LW +: LW]);
    assign o_l = llr_t'(old_grp[l*LW +: LW]);
    assign v_l = clamp_llr(sum_t'(p_l) - sum_t'(o_l));

    ldpc_min2_track #(.EW(EW), .NONE(NV)) u_trk (
      .clk(clk), .rst(rst),
      .first(st_q == ST_GATHER && edge_q == '0),
      .en(st_q == ST_GATHER && has_edge),
      .eidx(edge_q), .v2c(v_l),
      .min1(m1), .min2(m2), .idx(ix), .sgn(sp));

    assign nm  = (ix == edge_q) ? scale_mag(m2) : scale_mag(m1);
    assign n_l = (sp ^ v_l[LW-1]) ? -llr_t'(nm) : llr_t'(nm);

    assign new_c2v_grp[l*LW +: LW] = n_l;
    assign new_rot_grp[l*LW +: LW] =
      clamp_llr(sum_t'(p_l) + sum_t'(n_l) - sum_t'(o_l));
    assign ld_sat[l*LW +: LW] = clamp_llr(sum_t'(llr_t'(ld_data[l*LW +: LW])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      edge_q     <= '0;
      row_q      <= '0;
      iter_q     <= '0;
      max_q      <= '0;
      early_q    <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      iter_count <= '0;
      parity_ok  <= 1'b0;
      rd_data    <= '0;
      for (int g = 0; g < int'(NV); g++)    post_mem[g] <= '0;
      for (int c = 0; c < int'(NSLOT); c++) c2v_mem[c]  <= '0;
    end else begin
      done    <= 1'b0;
      rd_data <= (rd_grp < EW'(NV)) ? post_mem[rd_grp] : '0;
      case (st_q)
        ST_IDLE: begin
          if (ld_en && ld_grp < EW'(NV)) post_mem[ld_grp] <= ld_sat;
          if (start) begin
            for (int c = 0; c < int'(NSLOT); c++) c2v_mem[c] <= '0;
            max_q   <= (max_iter == '0) ? ITER_W'(1) : max_iter;
            early_q <= early_stop;
            iter_q  <= '0;
            row_q   <= '0;
            edge_q  <= '0;
            busy    <= 1'b1;
            st_q    <= ST_GATHER;
          end
        end
        ST_GATHER: begin
          if (last_edge) begin
            edge_q <= '0;
            st_q   <= ST_APPLY;
          end else begin
            edge_q <= edge_q + 1'b1;
          end
        end
        ST_APPLY: begin
          if (has_edge) begin
            post_mem[edge_q]  <= post_wb;
            c2v_mem[slot_idx] <= new_c2v_grp;
          end
          if (last_edge) begin
            edge_q <= '0;
            if (row_q == RW'(NR - 1)) begin
              row_q <= '0;
              st_q  <= ST_CHECK;
            end else begin
              row_q <= row_q + 1'b1;
              st_q  <= ST_GATHER;
            end
          end else begin
            edge_q <= edge_q + 1'b1;
          end
        end
        ST_CHECK: begin
          if ((early_q && synd_ok) || (iter_q + 1'b1 == max_q)) begin
            done       <= 1'b1;
            busy       <= 1'b0;
            parity_ok  <= synd_ok;
            iter_count <= iter_q + 1'b1;
            st_q       <= ST_IDLE;
          end else begin
            iter_q <= iter_q + 1'b1;
            st_q   <= ST_GATHER;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldpc_layer_dec_chk.sv
module ldpc_layer_dec_chk #(
  parameter int unsigned Z      = 4,
  parameter int unsigned ITER_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              parity_ok,
  input logic              early_q,
  input logic [ITER_W-1:0] iter_count,
  input logic [ITER_W-1:0] max_q,
  input logic [Z*8-1:0]    rd_data
);
  logic rd_in_range;

  always_comb begin
    rd_in_range = 1'b1;
    for (int l = 0; l < int'(Z); l++) begin
      if ($signed(rd_data[l*8 +: 8]) > 64 || $signed(rd_data[l*8 +: 8]) < -64)
        rd_in_range = 1'b0;
    end
  end

  assert_post_range_R5: assert property (@(posedge clk) disable iff (rst)
    rd_in_range);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_iter_bound_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (iter_count != '0 && iter_count <= max_q));

  assert_early_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (done && early_q && iter_count != max_q) |-> parity_ok);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(iter_count));
endmodule

bind ldpc_layer_dec ldpc_layer_dec_chk #(.Z(Z), .ITER_W(ITER_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .parity_ok(parity_ok), .early_q(early_q), .iter_count(iter_count),
  .max_q(max_q), .rd_data(rd_data));

// File: tb/sim_ldpc_layer_dec.sv
`timescale 1ns/1ps
module sim_ldpc_layer_dec;
  localparam int Z = 4, NV = 6, NR = 3, IW = 4, GW = Z*8;
  localparam int EW = $clog2(NV+1);

  logic clk = 0, rst = 1;
  logic ld_en = 0, start = 0, early_stop = 0;
  logic [EW-1:0] ld_grp = '0, rd_grp = '0;
  logic [GW-1:0] ld_data = '0;
  wire  [GW-1:0] rd_data;
  logic [NR*NV*16-1:0] shift_tab = '1;
  logic [IW-1:0] max_iter = '0;
  wire busy, done, parity_ok;
  wire [IW-1:0] iter_count;

  ldpc_layer_dec #(.Z(Z), .NV(NV), .NR(NR), .ITER_W(IW)) u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_grp(ld_grp), .ld_data(ld_data),
    .rd_grp(rd_grp), .rd_data(rd_data), .shift_tab(shift_tab), .start(start),
    .max_iter(max_iter), .early_stop(early_stop), .busy(busy), .done(done),
    .iter_count(iter_count), .parity_ok(parity_ok));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int raw [NV][Z];
  int mpost [NV][Z];
  int mc2v [NR][NV][Z];
  int shf [NR][NV];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic int clampi(int x);
    return (x > 64) ? 64 : ((x < -64) ? -64 : x);
  endfunction
  function automatic int scalei(int m);
    return (m * 13) >> 4;
  endfunction
  function automatic int absi(int x);
    return (x < 0) ? -x : x;
  endfunction
  function automatic logic [GW-1:0] pack_model(int g);
    logic [GW-1:0] v;
    for (int l = 0; l < Z; l++) v[l*8 +: 8] = 8'(mpost[g][l]);
    return v;
  endfunction
  function automatic logic [GW-1:0] fill(int x);
    logic [GW-1:0] v;
    for (int l = 0; l < Z; l++) v[l*8 +: 8] = 8'(x);
    return v;
  endfunction

  function automatic bit model_parity();
    for (int r = 0; r < NR; r++)
      for (int l = 0; l < Z; l++) begin
        bit p = 0;
        for (int e = 0; e < NV; e++)
          if (shf[r][e] >= 0) p ^= (mpost[e][(l + shf[r][e]) % Z] < 0);
        if (p) return 0;
      end
    return 1;
  endfunction

  task automatic model_layer(int r);
    for (int l = 0; l < Z; l++) begin
      int m1 = 64, m2 = 64, ix = -1;
      bit sp = 0;
      for (int e = 0; e < NV; e++) if (shf[r][e] >= 0) begin
        int v = clampi(mpost[e][(l + shf[r][e]) % Z] - mc2v[r][e][l]);
        if (absi(v) < m1) begin m2 = m1; m1 = absi(v); ix = e; end
        else if (absi(v) < m2) m2 = absi(v);
        sp ^= (v < 0);
      end
      for (int e = 0; e < NV; e++) if (shf[r][e] >= 0) begin
        int k = (l + shf[r][e]) % Z;
        int v = clampi(mpost[e][k] - mc2v[r][e][l]);
        int nm = (e == ix) ? scalei(m2) : scalei(m1);
        int nc = (sp ^ (v < 0)) ? -nm : nm;
        mpost[e][k] = clampi(mpost[e][k] + nc - mc2v[r][e][l]);
        mc2v[r][e][l] = nc;
      end
    end
  endtask

  task automatic model_run(input int mx, input bit es, output int its, output bit ok);
    int mxe = (mx == 0) ? 1 : mx;
    for (int r = 0; r < NR; r++) for (int e = 0; e < NV; e++)
      for (int l = 0; l < Z; l++) mc2v[r][e][l] = 0;
    its = 0;
    forever begin
      for (int r = 0; r < NR; r++) model_layer(r);
      its++;
      ok = model_parity();
      if ((es && ok) || its == mxe) break;
    end
  endtask

  task automatic apply_table();
    for (int r = 0; r < NR; r++) for (int e = 0; e < NV; e++)
      shift_tab[(r*NV + e)*16 +: 16] = (shf[r][e] < 0) ? 16'hFFFF : 16'(shf[r][e]);
  endtask

  task automatic load_all();
    for (int g = 0; g < NV; g++) begin
      @(negedge clk);
      ld_en = 1; ld_grp = EW'(g);
      for (int l = 0; l < Z; l++) begin
        ld_data[l*8 +: 8] = 8'(raw[g][l]);
        mpost[g][l] = clampi(raw[g][l]);
      end
    end
    @(negedge clk); ld_en = 0;
  endtask

  task automatic read_grp(input int g, output logic [GW-1:0] v);
    @(negedge clk); rd_grp = EW'(g);
    @(negedge clk); v = rd_data;
  endtask

  task automatic compare_all(input string tag);
    logic [GW-1:0] v;
    for (int g = 0; g < NV; g++) begin
      read_grp(g, v);
      check(tag, v, pack_model(g));
    end
  endtask

  task automatic run_dut(input int mx, input bit es, input bit poke);
    @(negedge clk);
    start = 1; max_iter = IW'(mx); early_stop = es;
    @(negedge clk);
    start = 0;
    check("R9 busy after start", busy, 1);
    if (poke) begin
      start = 1; ld_en = 1; ld_grp = '0; ld_data = fill(50);
      @(negedge clk);
      start = 0; ld_en = 0;
    end
    while (done !== 1'b1) @(negedge clk);
    @(negedge clk);
    check("R9 done one cycle", done, 0);
  endtask

  task automatic run_both(input string tag, input int mx, input bit es, input bit poke);
    int its; bit ok;
    run_dut(mx, es, poke);
    model_run(mx, es, its, ok);
    check({tag, " iter_count"}, iter_count, its);
    check({tag, " parity_ok"}, parity_ok, ok);
    compare_all({tag, " posteriors"});
  endtask

  task automatic clear_setup();
    for (int r = 0; r < NR; r++) for (int e = 0; e < NV; e++) shf[r][e] = -1;
    for (int g = 0; g < NV; g++) for (int l = 0; l < Z; l++) raw[g][l] = 0;
  endtask

  task automatic random_setup(input int lim);
    for (int r = 0; r < NR; r++) for (int e = 0; e < NV; e++)
      shf[r][e] = ($urandom % 3 == 0) ? -1 : int'($urandom % Z);
    for (int g = 0; g < NV; g++) for (int l = 0; l < Z; l++)
      raw[g][l] = int'($urandom % (2*lim + 1)) - lim;
  endtask

  initial begin
    logic [GW-1:0] v;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    check("R10 iter_count", iter_count, 0);
    read_grp(0, v);
    check("R10 posterior", v, 0);

    // R1 load clamping and readback
    @(negedge clk);
    ld_en = 1; ld_grp = 0; ld_data = {8'(-65), 8'd64, 8'(-100), 8'd100};
    @(negedge clk); ld_en = 0;
    read_grp(0, v);
    check("R1 clamped load", v, {8'(-64), 8'd64, 8'(-64), 8'd64});

    // R3 R4 basic: edges 0,1; 40 and -20 -> 24 and 12
    clear_setup();
    shf[0][0] = 0; shf[0][1] = 0;
    for (int l = 0; l < Z; l++) begin raw[0][l] = 40; raw[1][l] = -20; end
    apply_table(); load_all();
    run_dut(1, 0, 0);
    read_grp(0, v); check("R4 scaled min edge0", v, fill(24));
    read_grp(1, v); check("R3 second min edge1", v, fill(12));

    // R3 ties: 30, 30, -30 -> 6, 6, -6
    clear_setup();
    shf[0][0] = 0; shf[0][1] = 0; shf[0][2] = 0;
    for (int l = 0; l < Z; l++) begin raw[0][l] = 30; raw[1][l] = 30; raw[2][l] = -30; end
    apply_table(); load_all();
    run_dut(1, 0, 0);
    read_grp(0, v); check("R3 tie edge0", v, fill(6));
    read_grp(1, v); check("R3 tie edge1", v, fill(6));
    read_grp(2, v); check("R3 tie sign edge2", v, fill(-6));

    // R5 saturation: 64 and 60 both end at 64
    clear_setup();
    shf[0][0] = 0; shf[0][1] = 0;
    for (int l = 0; l < Z; l++) begin raw[0][l] = 64; raw[1][l] = 60; end
    apply_table(); load_all();
    run_dut(1, 0, 0);
    read_grp(0, v); check("R5 clamp edge0", v, fill(64));
    read_grp(1, v); check("R5 clamp edge1", v, fill(64));

    // R6 rotation and absent edges against the model
    clear_setup();
    shf[0][0] = 1; shf[0][1] = 3; shf[0][3] = 2;
    shf[1][1] = 2; shf[1][2] = 1; shf[1][4] = 0;
    shf[2][0] = 3; shf[2][4] = 1; shf[2][5] = 2;
    for (int g = 0; g < NV; g++) for (int l = 0; l < Z; l++) raw[g][l] = (g*Z + l)*7 % 61 - 30;
    apply_table(); load_all();
    run_both("R6 rotated layers", 2, 0, 0);

    // R7 valid codeword: early stop on and off, max_iter 0
    random_setup(20);
    for (int g = 0; g < NV; g++) for (int l = 0; l < Z; l++) raw[g][l] = 20;
    apply_table(); load_all();
    run_both("R7 early stop", 5, 1, 0);
    check("R7 early stop count", iter_count, 1);
    load_all();
    run_both("R7 no early stop", 3, 0, 0);
    check("R7 full count", iter_count, 3);
    load_all();
    run_both("R7 zero limit", 0, 0, 0);
    check("R7 zero limit count", iter_count, 1);

    // R8 repeated decode of identical data
    random_setup(50);
    apply_table(); load_all();
    run_both("R8 first decode", 3, 0, 0);
    load_all();
    run_both("R8 repeat decode", 3, 0, 0);

    // R9 start and load while busy are ignored
    random_setup(50);
    apply_table(); load_all();
    run_both("R9 poke while busy", 2, 0, 1);

    // R2 random tables and values
    for (int t = 0; t < 25; t++) begin
      random_setup(80);
      apply_table(); load_all();
      run_both("R2 random", int'($urandom % 7), bit'($urandom % 2), 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule